// File: doc/BRIEF.md
# Double Auto-Zero Line Readout Sequencer

This block sequences one horizontal line of a column single-slope digitizer that uses correlated double sampling. A single line-start strobe launches two readout phases: first the pixel reset level, then the signal level. The comparator is auto-zeroed before each ramp, on the reset level and again on the signal level. Both comparisons therefore cross at the same common-mode point. The block drives the row select, the reset and transfer input selects, the two auto-zero switch phases, the ramp enable and the enables of the reset and signal counters. It raises a done pulse when the line is complete.

Three lengths are programmable and are captured when a line starts: the dead time between signals that must never overlap, the auto-zero length and the settle gap before each ramp. The two ramp lengths are design parameters. The reset ramp is `RST_CNT` cycles long. The signal ramp is `RST_CNT + SIG_CNT` cycles long, and the signal count is enabled only after its first `RST_CNT` cycles. A strobe that arrives while a line is running has no effect on the sequence and sets a sticky overrun flag.

Top module: `cds_line_sequencer`

## Requirements
- R1: `row_sel` is one-hot, with bit i selecting row `row_idx` = i, captured when the line is accepted. It is high from the first cycle after the accepting edge through the done cycle, and zero when idle.
- R2: Cycle k=0 is the first cycle after the accepting edge. Each phase starts with D cycles with both input selects low. `rst_sel` covers the whole reset phase and `tx_sel` the whole signal phase, and the two are never high together.
- R3: Each phase has one auto-zero step with `az_phi1` high for A cycles, then D cycles with both phases low, then `az_phi2` high. The two phases never overlap, so there are two auto-zero steps per line.
- R4: `az_phi2` is high for S settle cycles before `ramp_en` rises and stays high until the ramp ends.
- R5: The reset ramp lasts `RST_CNT` cycles, and `rcnt_en` is high in exactly those cycles, rising together with `ramp_en`.
- R6: The signal ramp lasts `RST_CNT + SIG_CNT` cycles. `scnt_en` rises `RST_CNT` cycles after that ramp starts and stays high until the ramp ends, and it is high only inside the signal ramp.
- R7: `ramp_en` is low outside the two ramp intervals.
- R8: D, A and S are the values of `dead_len`, `az_len` and `settle_len` captured at acceptance, with a value of 0 taken as 1. Changing these inputs during a line has no effect.
- R9: `scan_done` is high for exactly one cycle, the cycle after the last signal-ramp cycle. All outputs except `overrun` are zero in the cycle after that.
- R10: A `line_start` that arrives while a line is active, including the done cycle, neither restarts nor alters the sequence. It sets `overrun`, which then stays high until reset.
- R11: During and after reset, before any strobe, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Starts a line when the block is idle |
| row_idx | input | ROW_W | Row to read, captured at acceptance |
| dead_len | input | LEN_W | Dead time at break-before-make points (0 taken as 1) |
| az_len | input | LEN_W | Auto-zero length (0 taken as 1) |
| settle_len | input | LEN_W | Settle gap before each ramp (0 taken as 1) |
| row_sel | output | ROWS | One-hot row select |
| rst_sel | output | 1 | Reset-level input select |
| tx_sel | output | 1 | Signal-level (transfer) input select |
| az_phi1 | output | 1 | Auto-zero switch phase |
| az_phi2 | output | 1 | Ramp-connect switch phase |
| ramp_en | output | 1 | Ramp run enable (low returns the ramp to its top value) |
| rcnt_en | output | 1 | Reset counter enable |
| scnt_en | output | 1 | Signal counter enable |
| scan_done | output | 1 | One-cycle end-of-line pulse |
| overrun | output | 1 | Sticky flag for a line strobe that was ignored |

## Verification
A wrong state or a phase counter that is out by one shows up at once as a shifted edge on one of the registered strobes. The bench compares every output on every cycle of a line against an arithmetic timeline, so such a slip is reported in the cycle where it first appears. A phase bit stuck at the wrong value swaps `rst_sel` and `tx_sel`, or shows `rcnt_en` in the signal ramp, during the first ramp. A broken capture of the lengths or of the row shows up only after the inputs change in the middle of a line, so the bench changes them there on every line.

// File: rtl/cds_seq_pkg.sv
package cds_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MUXGAP = 3'd1,
    ST_AZ     = 3'd2,
    ST_AZGAP  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RAMP   = 3'd5,
    ST_DONE   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/az_phase_fsm.sv
module az_phase_fsm
  import cds_seq_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int CNT_W   = 14,
  parameter int RST_CNT = 256,
  parameter int SIG_CNT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [LEN_W-1:0] dead_len,
  input  logic [LEN_W-1:0] az_len,
  input  logic [LEN_W-1:0] settle_len,
  output seq_state_e       state_d,
  output logic             phase_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             accept,
  output logic             busy
);
  localparam logic [CNT_W-1:0] RAMP0_LEN = CNT_W'(RST_CNT);
  localparam logic [CNT_W-1:0] RAMP1_LEN = CNT_W'(RST_CNT + SIG_CNT);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);

  seq_state_e       state_q;
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] dead_q, az_q, settle_q;
  logic [CNT_W-1:0] len_cur;
  logic             last;

  assign busy   = (state_q != ST_IDLE);
  assign accept = line_start && !busy;

  // lengths captured at acceptance, zero promoted to one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q   <= LEN_ONE;
      az_q     <= LEN_ONE;
      settle_q <= LEN_ONE;
    end else if (accept) begin
      dead_q   <= (dead_len   == '0) ? LEN_ONE : dead_len;
      az_q     <= (az_len     == '0) ? LEN_ONE : az_len;
      settle_q <= (settle_len == '0) ? LEN_ONE : settle_len;
    end
  end

  always_comb begin
    case (state_q)
      ST_MUXGAP, ST_AZGAP: len_cur = CNT_W'(dead_q);
      ST_AZ:               len_cur = CNT_W'(az_q);
      ST_SETTLE:           len_cur = CNT_W'(settle_q);
      ST_RAMP:             len_cur = phase_q ? RAMP1_LEN : RAMP0_LEN;
      default:             len_cur = CNT_W'(1);
    endcase
  end

  assign last = (cnt_q == len_cur - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = last ? '0 : cnt_q + CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          state_d = ST_MUXGAP;
          phase_d = 1'b0;
        end
      end
      ST_MUXGAP: if (last) state_d = ST_AZ;
      ST_AZ:     if (last) state_d = ST_AZGAP;
      ST_AZGAP:  if (last) state_d = ST_SETTLE;
      ST_SETTLE: if (last) state_d = ST_RAMP;
      ST_RAMP: begin
        if (last) begin
          if (phase_q) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_MUXGAP;
            phase_d = 1'b1;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/az_out_reg.sv
module az_out_reg
  import cds_seq_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int ROW_W   = 3,
  parameter int CNT_W   = 14,
  parameter int RST_CNT = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state_d,
  input  logic             phase_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             accept,
  input  logic [ROW_W-1:0] row_idx,
  output logic [ROWS-1:0]  row_sel,
  output logic             rst_sel,
  output logic             tx_sel,
  output logic             az_phi1,
  output logic             az_phi2,
  output logic             ramp_en,
  output logic             rcnt_en,
  output logic             scnt_en,
  output logic             scan_done
);
  logic [ROW_W-1:0] row_hold_q, row_cur;
  logic [ROWS-1:0]  row_sel_d;
  logic             active, in_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_hold_q <= '0;
    else if (accept) row_hold_q <= row_idx;
  end

  assign row_cur = accept ? row_idx : row_hold_q;
  assign active  = (state_d != ST_IDLE);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_sel_d[i] = active && (row_cur == ROW_W'(i));
  end

  assign in_phase = (state_d == ST_AZ) || (state_d == ST_AZGAP) ||
                    (state_d == ST_SETTLE) || (state_d == ST_RAMP);

  // outputs registered from the next state: glitch-free strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel   <= '0;
      rst_sel   <= 1'b0;
      tx_sel    <= 1'b0;
      az_phi1   <= 1'b0;
      az_phi2   <= 1'b0;
      ramp_en   <= 1'b0;
      rcnt_en   <= 1'b0;
      scnt_en   <= 1'b0;
      scan_done <= 1'b0;
    end else begin
      row_sel   <= row_sel_d;
      rst_sel   <= in_phase && !phase_d;
      tx_sel    <= in_phase && phase_d;
      az_phi1   <= (state_d == ST_AZ);
      az_phi2   <= (state_d == ST_SETTLE) || (state_d == ST_RAMP);
      ramp_en   <= (state_d == ST_RAMP);
      rcnt_en   <= (state_d == ST_RAMP) && !phase_d;
      scnt_en   <= (state_d == ST_RAMP) && phase_d && (cnt_d >= CNT_W'(RST_CNT));
      scan_done <= (state_d == ST_DONE);
    end
  end
endmodule

// File: rtl/cds_line_sequencer.sv
module cds_line_sequencer
  import cds_seq_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int LEN_W   = 4,
  parameter int RST_CNT = 256,
  parameter int SIG_CNT = 4096,
  parameter int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [ROW_W-1:0] row_idx,
  input  logic [LEN_W-1:0] dead_len,
  input  logic [LEN_W-1:0] az_len,
  input  logic [LEN_W-1:0] settle_len,
  output logic [ROWS-1:0]  row_sel,
  output logic             rst_sel,
  output logic             tx_sel,
  output logic             az_phi1,
  output logic             az_phi2,
  output logic             ramp_en,
  output logic             rcnt_en,
  output logic             scnt_en,
  output logic             scan_done,
  output logic             overrun
);
  localparam int RAMP_W = $clog2(RST_CNT + SIG_CNT + 1);
  localparam int CNT_W  = ((RAMP_W > LEN_W) ? RAMP_W : LEN_W) + 1;

  seq_state_e       state_d;
  logic             phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             accept, busy;

  az_phase_fsm #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .RST_CNT(RST_CNT), .SIG_CNT(SIG_CNT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .dead_len(dead_len), .az_len(az_len), .settle_len(settle_len),
    .state_d(state_d), .phase_d(phase_d), .cnt_d(cnt_d),
    .accept(accept), .busy(busy)
  );

  az_out_reg #(
    .ROWS(ROWS), .ROW_W(ROW_W), .CNT_W(CNT_W), .RST_CNT(RST_CNT)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .phase_d(phase_d),
    .cnt_d(cnt_d), .accept(accept), .row_idx(row_idx),
    .row_sel(row_sel), .rst_sel(rst_sel), .tx_sel(tx_sel),
    .az_phi1(az_phi1), .az_phi2(az_phi2), .ramp_en(ramp_en),
    .rcnt_en(rcnt_en), .scnt_en(scnt_en), .scan_done(scan_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  overrun <= 1'b0;
    else if (line_start && busy) overrun <= 1'b1;
  end
endmodule

// File: rtl/cds_seq_checker.sv
module cds_seq_checker #(
  parameter int ROWS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ROWS-1:0] row_sel,
  input logic            rst_sel,
  input logic            tx_sel,
  input logic            az_phi1,
  input logic            az_phi2,
  input logic            ramp_en,
  input logic            rcnt_en,
  input logic            scnt_en,
  input logic            scan_done,
  input logic            overrun
);
  a_r1_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));
  a_r2_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_sel && tx_sel));
  a_r3_phi_nonoverlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(az_phi1 && az_phi2));
  a_r3_phi2_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(az_phi2) |-> !$past(az_phi1));
  a_r4_ramp_needs_phi2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> az_phi2);
  a_r5_rcnt_with_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcnt_en) |-> $rose(ramp_en) && rst_sel);
  a_r6_scnt_in_sig_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    scnt_en |-> ramp_en && tx_sel && !rcnt_en);
  a_r7_ramp_has_select: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> (rst_sel || tx_sel));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done && (row_sel == '0));
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind cds_line_sequencer cds_seq_checker #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .rst_sel(rst_sel),
  .tx_sel(tx_sel), .az_phi1(az_phi1), .az_phi2(az_phi2), .ramp_en(ramp_en),
  .rcnt_en(rcnt_en), .scnt_en(scnt_en), .scan_done(scan_done),
  .overrun(overrun)
);

// File: tb/test_cds_line_sequencer.sv
module test_cds_line_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int ROW_W = 3;
  localparam int LEN_W = 3;
  localparam int RST_CNT = 4;
  localparam int SIG_CNT = 8;

  logic clk, rst_n, line_start;
  logic [ROW_W-1:0] row_idx;
  logic [LEN_W-1:0] dead_len, az_len, settle_len;
  logic [ROWS-1:0] row_sel;
  logic rst_sel, tx_sel, az_phi1, az_phi2, ramp_en, rcnt_en, scnt_en, scan_done, overrun;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit ovr_exp = 0;

  cds_line_sequencer #(
    .ROWS(ROWS), .LEN_W(LEN_W), .RST_CNT(RST_CNT), .SIG_CNT(SIG_CNT)
  ) i_cds_line_sequencer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .row_idx(row_idx),
    .dead_len(dead_len), .az_len(az_len), .settle_len(settle_len),
    .row_sel(row_sel), .rst_sel(rst_sel), .tx_sel(tx_sel),
    .az_phi1(az_phi1), .az_phi2(az_phi2), .ramp_en(ramp_en),
    .rcnt_en(rcnt_en), .scnt_en(scnt_en), .scan_done(scan_done),
    .overrun(overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  // compare all outputs against the arithmetic timeline at cycle k
  task automatic check_cycle(input int k, input int d, input int a, input int s, input int row);
    int l = 2*d + a + s;
    int r0 = RST_CNT;
    int r1 = RST_CNT + SIG_CNT;
    int t = 2*l + r0 + r1 + 1;
    int p = 0;
    int j = 0;
    bit run = 0;
    bit e_sel = 0, e_phi1 = 0, e_phi2 = 0, e_ramp = 0, e_rcnt = 0, e_scnt = 0, e_done = 0;
    logic [ROWS-1:0] e_row = '0;
    if (k < l + r0) begin
      p = 0; j = k; run = 1;
    end else if (k < 2*l + r0 + r1) begin
      p = 1; j = k - (l + r0); run = 1;
    end
    if (k == t - 1) e_done = 1;
    if (k < t) e_row = ROWS'(1) << row;
    if (run) begin
      e_sel  = (j >= d);
      e_phi1 = (j >= d) && (j < d + a);
      e_phi2 = (j >= 2*d + a);
      e_ramp = (j >= l);
      e_rcnt = e_ramp && (p == 0);
      e_scnt = e_ramp && (p == 1) && (j - l >= RST_CNT);
    end
    chk("R1 row_sel", k, 32'(row_sel), 32'(e_row));
    chk("R2 rst_sel", k, 32'(rst_sel), 32'(e_sel && p == 0 && run));
    chk("R2 tx_sel", k, 32'(tx_sel), 32'(e_sel && p == 1 && run));
    chk("R3 az_phi1", k, 32'(az_phi1), 32'(e_phi1));
    chk("R4 az_phi2", k, 32'(az_phi2), 32'(e_phi2));
    chk("R7 ramp_en", k, 32'(ramp_en), 32'(e_ramp));
    chk("R5 rcnt_en", k, 32'(rcnt_en), 32'(e_rcnt));
    chk("R6 scnt_en", k, 32'(scnt_en), 32'(e_scnt));
    chk("R9 scan_done", k, 32'(scan_done), 32'(e_done));
    chk("R10 overrun", k, 32'(overrun), 32'(ovr_exp));
  endtask

  // one line; lengths and row are disturbed after acceptance (R8, R1)
  task automatic run_line(input int dl, input int al, input int sl, input int row,
                          input int inj_k, input bit inj_done);
    int d = (dl == 0) ? 1 : dl;
    int a = (al == 0) ? 1 : al;
    int s = (sl == 0) ? 1 : sl;
    int t = 2*(2*d + a + s) + RST_CNT + (RST_CNT + SIG_CNT) + 1;
    @(negedge clk);
    row_idx = ROW_W'(row); dead_len = LEN_W'(dl); az_len = LEN_W'(al); settle_len = LEN_W'(sl);
    line_start = 1'b1;
    for (int k = 0; k <= t + 1; k++) begin
      @(negedge clk);
      line_start = 1'b0;
      row_idx = ROW_W'(row) ^ ROW_W'(5);
      dead_len = ~LEN_W'(dl); az_len = ~LEN_W'(al); settle_len = ~LEN_W'(sl);
      check_cycle(k, d, a, s, row);
      if (k == inj_k || (inj_done && k == t - 1)) begin
        line_start = 1'b1;   // R10: ignored strobe while busy
        ovr_exp = 1'b1;      // visible from the next sample on
      end
    end
  endtask

  initial begin
    int n = 0;
    rst_n = 1'b0; line_start = 1'b0; row_idx = '0;
    dead_len = '0; az_len = '0; settle_len = '0;
    repeat (3) @(negedge clk);
    check_cycle(1000, 1, 1, 1, 0);   // R11 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_cycle(1000, 1, 1, 1, 0);   // R11 after release
    foreach (row_sel[b]) chk("R11 row_sel bit", b, 32'(row_sel[b]), 32'd0);
    for (int dl = 0; dl < 4; dl++) begin
      for (int ai = 0; ai < 3; ai++) begin
        for (int si = 0; si < 3; si++) begin
          int al = (ai == 0) ? 0 : (ai == 1) ? 1 : 5;
          int sl = (si == 0) ? 0 : (si == 1) ? 2 : 7;
          run_line(dl, al, sl, n % ROWS, -1, 1'b0);
          n++;
        end
      end
    end
    run_line(2, 3, 1, 6, 9, 1'b0);    // R10 strobe mid-line
    run_line(1, 2, 3, 3, -1, 1'b1);   // R10 strobe on the done cycle
    run_line(3, 1, 2, 7, 0, 1'b0);    // R10 strobe at the first active cycle
    chk("R10 overrun stays set", 0, 32'(overrun), 32'd1);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule